// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder and Decoder

This block sits between a UART and an infrared transceiver. On the transmit side it takes the UART serial data line and the UART's sixteen-times-baud enable. For every zero bit it drives a short HIGH pulse on the infrared output. A one bit leaves the output LOW. On the receive side it takes the transceiver's active-low output. It checks each incoming light pulse, then stretches any valid pulse into a full-bit zero on the UART receive line.

There are two pulse-width modes. Normal mode sends a pulse of three baud/16 ticks, which is 3/16 of a bit. Low-power mode sends a pulse of exactly three periods of a low-power tick, whatever the baud rate. That tick is made by dividing the clock by `lp_div + 1`. The receive side validates a start pulse against the same low-power tick period in both modes. This lets a normal-mode receiver accept the narrow pulses sent by a low-power transmitter. The link is half duplex. Software must provide the turnaround gap between sending and receiving.

Top module: `sir_codec`

## Requirements
- R1: After reset, `sir_out` is 0 and `rx_bit` is 1.
- R2: A bit period is 16 `baud16_tick` pulses. The first tick after reset, or after `sir_en` rises, starts a period. `tx_bit` is sampled only on that starting tick.
- R3: In normal mode (`lp_mode`=0), a sampled 0 makes `sir_out` HIGH from the cycle after the starting tick for exactly 3 tick spacings.
- R4: A sampled 1 keeps `sir_out` LOW for the whole bit period, even if `tx_bit` changes during the period.
- R5: In low-power mode (`lp_mode`=1, `lp_div`≠0), a sampled 0 makes `sir_out` HIGH from the cycle after the starting tick for exactly 3×(`lp_div`+1) clock cycles.
- R6: In low-power mode with `lp_div`=0, no pulse is sent.
- R7: `sir_in_n` passes through a two-flop synchronizer. A LOW is accepted as a pulse only if it is still LOW `lp_div`+1 cycles after it was first seen. That means at least `lp_div`+2 consecutive synchronized LOW samples.
- R8: An accepted pulse drives `rx_bit` to 0 until the 16th `baud16_tick` after acceptance.
- R9: A LOW shorter than the R7 threshold is rejected, and `rx_bit` stays 1.
- R10: Receive validation does not depend on `lp_mode`.
- R11: With `lp_div`=0, no receive pulse is ever accepted.
- R12: While `sir_en`=0, `sir_out` is 0 and `rx_bit` is 1, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sir_en | input | 1 | Enables the encoder and decoder |
| lp_mode | input | 1 | 1 selects fixed-width low-power pulses |
| lp_div | input | DIV_W | Low-power tick divisor; tick period is lp_div+1 cycles, 0 disables the tick |
| baud16_tick | input | 1 | One-cycle enable at sixteen times the baud rate |
| tx_bit | input | 1 | UART serial transmit data |
| sir_out | output | 1 | Infrared drive, HIGH means light |
| sir_in_n | input | 1 | Infrared receiver output, LOW means light |
| rx_bit | output | 1 | Decoded UART receive data |

## Verification
The bench uses the default 8-bit divisor width and spaces `baud16_tick` 8 cycles apart, so one bit period is 128 cycles. Divisors of 0, 1, 2, 3 and 5 give low-power pulses of 6 to 18 cycles. They also place the receive threshold at a few cycles. Because of this, the exact pulse widths, the accept/reject boundary one cycle either side, and the zero-divisor corner all fit inside short windows. Normal and low-power widths are set to differ so that a swapped mode shows up.

// File: rtl/sir_pkg.sv
package sir_pkg;
  localparam int BIT_TICKS   = 16;
  localparam int PULSE_STEPS = 3;
  localparam int PHASE_W     = $clog2(BIT_TICKS);
  localparam int STRETCH_W   = $clog2(BIT_TICKS + 1);

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_CHECK = 2'd1,
    RX_HOLD  = 2'd2
  } rx_state_t;
endpackage

// File: rtl/sir_lp_div.sv
module sir_lp_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             run;

  assign run  = en && (div != '0);
  assign tick = run && !restart && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt <= '0;
    end else if (cnt == div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sir_tx_shaper.sv
module sir_tx_shaper
  import sir_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             lp_mode,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             baud16_tick,
  input  logic             tx_bit,
  input  logic             lp_tick,
  output logic             boundary,
  output logic             pulse
);
  localparam int LEFT_W = $clog2(PULSE_STEPS);

  logic [PHASE_W-1:0] phase;
  logic [LEFT_W-1:0]  left;
  logic               lp_q;
  logic               step;
  logic               start;

  assign boundary = en && baud16_tick && (phase == '0);
  assign start    = boundary && !tx_bit && (!lp_mode || (lp_div != '0));
  assign step     = lp_q ? lp_tick : baud16_tick;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= '0;
    end else if (baud16_tick) begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pulse <= 1'b0;
      left  <= '0;
      lp_q  <= 1'b0;
    end else if (start) begin
      pulse <= 1'b1;
      left  <= LEFT_W'(PULSE_STEPS - 1);
      lp_q  <= lp_mode;
    end else if (pulse && step) begin
      if (left == '0) begin
        pulse <= 1'b0;
      end else begin
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sir_rx_decoder.sv
module sir_rx_decoder
  import sir_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sir_in_n,
  input  logic baud16_tick,
  input  logic lp_tick,
  output logic restart,
  output logic rx_bit
);
  logic [1:0]           sync;
  logic                 s_n;
  rx_state_t            state;
  logic [STRETCH_W-1:0] hold;

  assign s_n     = sync[1];
  assign restart = en && (state == RX_IDLE) && !s_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
    end else begin
      sync <= {sync[0], sir_in_n};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= RX_IDLE;
    end else begin
      case (state)
        RX_IDLE:  if (!s_n) state <= RX_CHECK;
        RX_CHECK: begin
          if (s_n) begin
            state <= RX_IDLE;
          end else if (lp_tick) begin
            state <= RX_HOLD;
          end
        end
        RX_HOLD:  if (s_n) state <= RX_IDLE;
        default:  state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      rx_bit <= 1'b1;
      hold   <= '0;
    end else if (state == RX_CHECK && !s_n && lp_tick) begin
      rx_bit <= 1'b0;
      hold   <= STRETCH_W'(BIT_TICKS);
    end else if (baud16_tick && hold != '0) begin
      hold <= hold - 1'b1;
      if (hold == STRETCH_W'(1)) begin
        rx_bit <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sir_codec.sv
module sir_codec #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sir_en,
  input  logic             lp_mode,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             baud16_tick,
  input  logic             tx_bit,
  output logic             sir_out,
  input  logic             sir_in_n,
  output logic             rx_bit
);
  logic tx_tick;
  logic tx_boundary;
  logic tx_restart;
  logic rx_tick;
  logic rx_restart;

  assign tx_restart = tx_boundary;

  sir_lp_div #(.DIV_W(DIV_W)) u_tx_div (
    .clk(clk), .rst(rst), .en(sir_en), .restart(tx_restart),
    .div(lp_div), .tick(tx_tick)
  );

  sir_lp_div #(.DIV_W(DIV_W)) u_rx_div (
    .clk(clk), .rst(rst), .en(sir_en), .restart(rx_restart),
    .div(lp_div), .tick(rx_tick)
  );

  sir_tx_shaper #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .en(sir_en), .lp_mode(lp_mode), .lp_div(lp_div),
    .baud16_tick(baud16_tick), .tx_bit(tx_bit), .lp_tick(tx_tick),
    .boundary(tx_boundary), .pulse(sir_out)
  );

  sir_rx_decoder u_rx (
    .clk(clk), .rst(rst), .en(sir_en), .sir_in_n(sir_in_n),
    .baud16_tick(baud16_tick), .lp_tick(rx_tick),
    .restart(rx_restart), .rx_bit(rx_bit)
  );
endmodule

// File: rtl/sir_codec_chk.sv
module sir_codec_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sir_en,
  input logic             lp_mode,
  input logic [DIV_W-1:0] lp_div,
  input logic             baud16_tick,
  input logic             sir_out,
  input logic             rx_bit
);
  // R12
  off_tx_low_chk: assert property (@(posedge clk) disable iff (rst)
    !sir_en |=> !sir_out);

  // R12
  off_rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sir_en |=> rx_bit);

  // R3
  pulse_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sir_out) |-> $past(baud16_tick));

  // R6
  lp_zero_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sir_out) |-> !($past(lp_mode) && $past(lp_div) == '0));

  // R11
  rx_needs_div_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_bit) |-> $past(lp_div) != '0);
endmodule

bind sir_codec sir_codec_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .sir_en(sir_en), .lp_mode(lp_mode), .lp_div(lp_div),
  .baud16_tick(baud16_tick), .sir_out(sir_out), .rx_bit(rx_bit)
);

// File: tb/sir_codec_test.sv
module sir_codec_test;
  localparam int DIV_W = 8;
  localparam int BT    = 8;
  localparam int WIN   = 16 * BT;
  localparam int NV    = 8;

  // {lp_mode, lp_div, tx_bit, expected high cycles}
  typedef struct packed {
    logic       lp;
    logic [7:0] dv;
    logic       b;
    logic [7:0] hi;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd2, 1'b0, 8'd24},
    '{1'b0, 8'd2, 1'b1, 8'd0},
    '{1'b1, 8'd2, 1'b0, 8'd9},
    '{1'b1, 8'd5, 1'b0, 8'd18},
    '{1'b1, 8'd0, 1'b0, 8'd0},
    '{1'b1, 8'd3, 1'b1, 8'd0},
    '{1'b0, 8'd0, 1'b0, 8'd24},
    '{1'b1, 8'd1, 1'b0, 8'd6}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sir_en = 1'b0;
  logic lp_mode = 1'b0;
  logic [DIV_W-1:0] lp_div = '0;
  logic baud16_tick = 1'b0;
  logic tx_bit = 1'b1;
  logic sir_in_n = 1'b1;
  logic sir_out;
  logic rx_bit;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sir_codec #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst(rst), .sir_en(sir_en), .lp_mode(lp_mode), .lp_div(lp_div),
    .baud16_tick(baud16_tick), .tx_bit(tx_bit), .sir_out(sir_out),
    .sir_in_n(sir_in_n), .rx_bit(rx_bit)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // One bit period: tx_bit b0, switched to b1 halfway; rx LOW for rxl cycles.
  task automatic window(input logic b0, input logic b1, input int rxl, input logic ticks,
                        output int hi, output int first, output int rxlow);
    hi = 0; first = -1; rxlow = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (sir_out) begin
        hi++;
        if (first < 0) first = i;
      end
      if (!rx_bit) rxlow++;
      tx_bit      = (i < WIN / 2) ? b0 : b1;
      baud16_tick = ticks && (i % BT == 0);
      sir_in_n    = !(i < rxl);
    end
  endtask

  task automatic rx_case(input logic lp, input int dv, input int len, output int low);
    int h, f, r1, r2;
    lp_mode = lp; lp_div = DIV_W'(dv);
    window(1'b1, 1'b1, len, 1'b1, h, f, r1);
    window(1'b1, 1'b1, 0, 1'b1, h, f, r2);
    low = r1 + r2;
  endtask

  initial begin
    int h, f, r;
    repeat (3) @(negedge clk);
    // R1
    check("R1 sir_out", int'(sir_out), 0);
    check("R1 rx_bit", int'(rx_bit), 1);
    rst = 1'b0;
    sir_en = 1'b1;

    for (int v = 0; v < NV; v++) begin
      lp_mode = VECS[v].lp;
      lp_div  = VECS[v].dv;
      window(VECS[v].b, VECS[v].b, 0, 1'b1, h, f, r);
      check($sformatf("R3/R4/R5/R6 width vec%0d", v), h, int'(VECS[v].hi));
      if (VECS[v].hi != 0) check($sformatf("R2 start vec%0d", v), f, 1);
    end

    // R4: a change to 0 in mid-period is not loaded
    lp_mode = 1'b0; lp_div = 8'd2;
    window(1'b1, 1'b0, 0, 1'b1, h, f, r);
    check("R4 mid-bit change", h, 0);
    // R2: the sampled value is held, next period sends the zero
    window(1'b0, 1'b0, 0, 1'b1, h, f, r);
    check("R2 next period", h, 24);

    // R9: 3 synchronized LOW cycles with divisor 2 is rejected
    rx_case(1'b0, 2, 3, r);
    check("R9 short pulse", r, 0);
    // R7 R8: 4 cycles accepted, held for 16 ticks
    rx_case(1'b0, 2, 4, r);
    check_rng("R7 R8 accepted stretch", r, 15 * BT, 16 * BT);
    // R10: same in low-power mode
    rx_case(1'b1, 2, 4, r);
    check_rng("R10 lp accept", r, 15 * BT, 16 * BT);
    rx_case(1'b1, 2, 3, r);
    check("R10 lp reject", r, 0);
    // R7: larger divisor moves the threshold
    rx_case(1'b0, 5, 6, r);
    check("R7 div5 reject", r, 0);
    rx_case(1'b0, 5, 7, r);
    check_rng("R7 div5 accept", r, 15 * BT, 16 * BT);
    // R11
    rx_case(1'b0, 0, 40, r);
    check("R11 zero divisor rx", r, 0);

    // R12
    sir_en = 1'b0; lp_mode = 1'b0; lp_div = 8'd2;
    window(1'b0, 1'b0, 40, 1'b1, h, f, r);
    check("R12 disabled tx", h, 0);
    check("R12 disabled rx", r, 0);
    // R2: after enable, the first tick starts a period again
    @(negedge clk);
    sir_en = 1'b1;
    window(1'b0, 1'b0, 0, 1'b1, h, f, r);
    check("R2 re-enable width", h, 24);
    check("R2 re-enable start", f, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule